// File: doc/BRIEF.md
# Three-Channel PWM Timer Bank

A bank of identical general-purpose timer channels sharing one register bus. Every channel holds a counter, a period, a pulse width and a configuration word. While a channel runs, its counter climbs once per clock and wraps back to zero one step short of the period. On each wrap the channel sets its interrupt latch. Its waveform output stays high while the count is below the pulse width.

Three shared registers act on all channels at once, one bit per channel, with bit `i` belonging to channel `i`. A start register and a stop register each respond only to the bits written as 1. A status register collects the interrupt latches. A latch stays set until software writes a 1 to its bit. A handler that returns without clearing its latch is therefore called again straight away.

Register access is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. Nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every counter, period, width, configuration, run bit and status latch reads 0, and all `pwm_out` and `irq` bits are 0.
- R2: The address map uses word addresses. Channel `c` register `r` sits at `c*4 + r`, where r=0 is the counter, 1 the period, 2 the width and 3 the configuration (bit 0 = interrupt enable). Address 28 is start, 29 is stop and 30 is status. Unused addresses read 0.
- R3: Writing the start register starts each channel whose bit is 1 and leaves channels with 0 bits untouched. Reading either the start or the stop register returns the run-state vector.
- R4: Writing the stop register stops each channel whose bit is 1 and leaves the others running. A stopped channel's counter holds its value.
- R5: A counter write is ignored while its channel runs. While the channel is stopped, a counter write presets the value it resumes from.
- R6: A running counter advances by 1 each clock. When it equals period−1 it returns to 0 instead. A period of 0 uses the full counter range.
- R7: `pwm_out[c]` is 1 exactly when channel c runs and its count is below its width. A width at or above the period gives a constant high; a width of 0 gives a constant low.
- R8: A channel's status latch is set at each wrap and stays set until a 1 is written to its status bit. Writing 0 has no effect. A wrap in the same cycle as a clear leaves the latch set.
- R9: `irq[c]` equals status latch c ANDed with configuration bit 0 of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 3 | Per-channel waveform |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The waveform is tried with:
- a period of 4 with width 2, which separates a correct duty cycle from an off-by-one compare;
- a period of 2 with width 1;
- a width above the period and a width of zero, which confirm the constant-level cases;
- a period of 1, where the latch sets on every edge and so tests set-over-clear priority;
- a period of 0, which shows that no early wrap occurs.

Resuming from a preset count shows whether the counter is preserved or restarted. Start and stop writes with mixed bit patterns show whether channels stay independent.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int MAX_CH   = 7;
  localparam logic [1:0] OFS_CNT = 2'd0;
  localparam logic [1:0] OFS_PER = 2'd1;
  localparam logic [1:0] OFS_WID = 2'd2;
  localparam logic [1:0] OFS_CFG = 2'd3;
  localparam logic [ADDR_W-1:0] ADR_START  = 5'd28;
  localparam logic [ADDR_W-1:0] ADR_STOP   = 5'd29;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'd30;

  typedef struct packed {
    logic cnt;
    logic per;
    logic wid;
    logic cfg;
  } chan_wr_t;
endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output chan_wr_t [NCH-1:0]      chan_wr,
  output logic [NCH-1:0]          start_set,
  output logic [NCH-1:0]          stop_set,
  output logic [NCH-1:0]          status_clr
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic [1:0]       ofs;

  assign sel = bus_addr[ADDR_W-1:2];
  assign ofs = bus_addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit = bus_wr && (sel == SEL_W'(c));
    assign chan_wr[c].cnt = hit && (ofs == OFS_CNT);
    assign chan_wr[c].per = hit && (ofs == OFS_PER);
    assign chan_wr[c].wid = hit && (ofs == OFS_WID);
    assign chan_wr[c].cfg = hit && (ofs == OFS_CFG);
    assign start_set[c]  = bus_wr && (bus_addr == ADR_START)  && bus_wdata[c];
    assign stop_set[c]   = bus_wr && (bus_addr == ADR_STOP)   && bus_wdata[c];
    assign status_clr[c] = bus_wr && (bus_addr == ADR_STATUS) && bus_wdata[c];
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_wr_t      wr,
  input  logic          start_set,
  input  logic          stop_set,
  input  logic          status_clr,
  input  logic [CW-1:0] wdata,
  output logic          running,
  output logic [CW-1:0] count,
  output logic [CW-1:0] period,
  output logic [CW-1:0] width,
  output logic          irq_en,
  output logic          latch,
  output logic          pwm,
  output logic          irq
);
  logic [CW-1:0] last;
  logic          at_end;

  assign last   = period - 1'b1;
  assign at_end = running && (count == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      period  <= '0;
      width   <= '0;
      irq_en  <= 1'b0;
      latch   <= 1'b0;
    end else begin
      if (stop_set)       running <= 1'b0;
      else if (start_set) running <= 1'b1;

      if (running) begin
        if (at_end) count <= '0;
        else        count <= count + 1'b1;
      end else if (wr.cnt) begin
        count <= wdata;
      end

      if (wr.per) period <= wdata;
      if (wr.wid) width  <= wdata;
      if (wr.cfg) irq_en <= wdata[0];

      if (at_end)          latch <= 1'b1;
      else if (status_clr) latch <= 1'b0;
    end
  end

  assign pwm = running && (count < width);
  assign irq = latch && irq_en;

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (count != period - 1'b1)) |=> (count == $past(count) + 1'b1));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (count == period - 1'b1)) |=> (count == '0) && latch);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr.cnt) |=> $stable(count));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !status_clr) |=> latch);
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pwm);
endmodule

// File: rtl/pwm_read_mux.sv
module pwm_read_mux
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NCH-1:0][CW-1:0]   count,
  input  logic [NCH-1:0][CW-1:0]   period,
  input  logic [NCH-1:0][CW-1:0]   width,
  input  logic [NCH-1:0]           irq_en,
  input  logic [NCH-1:0]           running,
  input  logic [NCH-1:0]           latch,
  output logic [DATA_W-1:0]        rdata
);
  localparam int SEL_W = ADDR_W - 2;

  always_comb begin
    rdata = '0;
    if (addr == ADR_START || addr == ADR_STOP) begin
      rdata = DATA_W'(running);
    end else if (addr == ADR_STATUS) begin
      rdata = DATA_W'(latch);
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (addr[ADDR_W-1:2] == SEL_W'(c)) begin
          case (addr[1:0])
            OFS_CNT: rdata = DATA_W'(count[c]);
            OFS_PER: rdata = DATA_W'(period[c]);
            OFS_WID: rdata = DATA_W'(width[c]);
            default: rdata = DATA_W'(irq_en[c]);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    irq
);
  chan_wr_t [NCH-1:0]    chan_wr;
  logic [NCH-1:0]        start_set, stop_set, status_clr;
  logic [NCH-1:0][CW-1:0] count, period, width;
  logic [NCH-1:0]        irq_en, running, latch;

  pwm_bus_decode #(.NCH(NCH)) u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .chan_wr    (chan_wr),
    .start_set  (start_set),
    .stop_set   (stop_set),
    .status_clr (status_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (chan_wr[c]),
      .start_set  (start_set[c]),
      .stop_set   (stop_set[c]),
      .status_clr (status_clr[c]),
      .wdata      (bus_wdata[CW-1:0]),
      .running    (running[c]),
      .count      (count[c]),
      .period     (period[c]),
      .width      (width[c]),
      .irq_en     (irq_en[c]),
      .latch      (latch[c]),
      .pwm        (pwm_out[c]),
      .irq        (irq[c])
    );
  end

  pwm_read_mux #(.NCH(NCH), .CW(CW)) u_mux (
    .addr    (bus_addr),
    .count   (count),
    .period  (period),
    .width   (width),
    .irq_en  (irq_en),
    .running (running),
    .latch   (latch),
    .rdata   (bus_rdata)
  );

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_START) |=>
      ((running & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));
  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_STOP) |=>
      ((running & $past(bus_wdata[NCH-1:0])) == '0));
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~latch) == '0);
endmodule

// File: tb/pwm_timer_bank_bench.sv
module pwm_timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  pwm_out, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timer_bank u_pwm_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 31; a++) begin
      rd(5'(a), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 reset pwm", 32'(pwm_out), 0);
    chk("R1 reset irq", 32'(irq), 0);
  endtask

  task automatic t_duty();
    wr(5'd1, 4); wr(5'd2, 2); wr(5'd3, 1);
    wr(5'd28, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 duty p4w2", 32'(pwm_out[0]), 32'((i % 4) < 2));
      chk("R9 irq on wrap", 32'(irq[0]), 32'(i >= 4));
    end
  endtask

  task automatic t_readonly_stop();
    logic [31:0] v, v2;
    wr(5'd0, 100);
    rd(5'd0, v);
    chk("R5 ro while running", 32'(v < 4), 1);
    rd(5'd28, v);
    chk("R3 start reads run", v, 1);
    wr(5'd29, 1);
    rd(5'd29, v);
    chk("R3 stop reads run", v, 0);
    rd(5'd0, v);
    repeat (3) @(negedge clk);
    rd(5'd0, v2);
    chk("R4 held when stopped", v2, v);
    chk("R7 low when stopped", 32'(pwm_out[0]), 0);
  endtask

  task automatic t_w1c_preset();
    logic [31:0] v;
    rd(5'd30, v);
    chk("R8 latch set", v & 1, 1);
    wr(5'd30, 0);
    rd(5'd30, v);
    chk("R8 write0 no clear", v & 1, 1);
    wr(5'd30, 1);
    rd(5'd30, v);
    chk("R8 w1c clears", v & 1, 0);
    chk("R9 irq drops", 32'(irq[0]), 0);
    wr(5'd0, 2);
    rd(5'd0, v);
    chk("R5 preset when stopped", v, 2);
    wr(5'd28, 1);
    @(negedge clk);
    chk("R5 resume cnt2 pwm", 32'(pwm_out[0]), 0);
    chk("R5 resume cnt2 irq", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 cnt3 irq", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 wrap pwm", 32'(pwm_out[0]), 1);
    chk("R6 wrap irq", 32'(irq[0]), 1);
    wr(5'd29, 1);
    wr(5'd30, 1);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    wr(5'd5, 2); wr(5'd6, 1);
    wr(5'd28, 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 duty p2w1", 32'(pwm_out[1]), 32'(i % 2 == 0));
    end
    rd(5'd30, v);
    chk("R8 ch1 latch", v, 2);
    chk("R9 irq masked", 32'(irq[1]), 0);
    wr(5'd28, 0);
    rd(5'd28, v);
    chk("R3 start write0 no effect", v, 2);
    wr(5'd9, 3); wr(5'd10, 5); wr(5'd11, 1);
    wr(5'd28, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 wide const high", 32'(pwm_out[2]), 1);
    end
    wr(5'd29, 2);
    rd(5'd28, v);
    chk("R4 stop only ch1", v, 4);
    wr(5'd10, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 zero width low", 32'(pwm_out[2]), 0);
    end
    wr(5'd29, 4);
  endtask

  task automatic t_period_one();
    logic [31:0] v;
    wr(5'd5, 1); wr(5'd4, 0); wr(5'd30, 7);
    wr(5'd28, 2);
    repeat (2) @(negedge clk);
    wr(5'd30, 2);
    rd(5'd30, v);
    chk("R8 set beats clear", v & 2, 2);
    rd(5'd4, v);
    chk("R6 period1 cnt0", v, 0);
    wr(5'd29, 2);
  endtask

  task automatic t_period_zero();
    logic [31:0] v;
    wr(5'd1, 0); wr(5'd0, 0); wr(5'd30, 1);
    wr(5'd28, 1);
    repeat (10) @(negedge clk);
    wr(5'd29, 1);
    rd(5'd0, v);
    chk("R6 period0 no early wrap", 32'(v >= 10), 1);
    rd(5'd30, v);
    chk("R6 period0 no latch", v & 1, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    rd(5'd31, v);
    chk("R2 unused addr", v, 0);
    rd(5'd11, v);
    chk("R2 cfg ch2", v, 1);
    rd(5'd9, v);
    chk("R2 period ch2", v, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_duty();
    t_readonly_stop();
    t_w1c_preset();
    t_multi();
    t_period_one();
    t_period_zero();
    t_map();
    done = 1;
  end

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule